// File: doc/BRIEF.md
# Windowed Raster Readout Sequencer

This block produces the pixel readout order for a raw colour-mosaic sensor array. A rectangular window, bounded by a programmable first and last row and a first and last column, can sit anywhere in the array. The sequencer walks that window in raster order, one pixel per clock. It drives a row and column address to an abstract sample source and places the returned value on a parallel pixel bus. Row decimation and column decimation can each be switched on separately. Either one keeps every second line or every second pixel, so both together cut the pixel count of a frame by four.

The sequencer is the bus master. No acknowledge comes back from the receiver. A data-ready pulse accompanies each pixel. An active-low end-of-row pulse follows the last pixel of every row, and an active-low end-of-frame pulse comes one cycle after that on the last row. A programmable number of idle cycles separates the rows, and a second count separates the frames. The window, the decimation bits, both blanking counts and the integration time (a 16-bit row count assembled from a high byte and a low byte, plus a fine sub-row value) are held in shadow copies. The shadow copies are refreshed only when a frame begins. Readout starts when the run input is high. When run drops, the current row completes and the sequencer then goes quiet.

Top module: `sensor_readout_seq`

## Requirements
- R1: While scanning, the sample address stays inside the active window. Rows are visited in increasing order, and within each row the columns are visited in increasing order, one pixel per clock. Each pixel carries the value that sample_data held for its address.
- R2: A first row above ROWS-4 is reduced to ROWS-4, and the same applies to a first column above COLS-4 (reduced to COLS-4). A last row below first+3 is raised to first+3, and a last row above ROWS-1 is reduced to ROWS-1. The last column follows the same rule.
- R3: With cfg_row_skip high, the rows visited are first, first+2, first+4 and so on, up to and including the last row.
- R4: With cfg_col_skip high, the columns visited are first, first+2 and so on, up to the last column. This setting is independent of R3.
- R5: pix_drdy is high for exactly one cycle per pixel. In that cycle pix_data holds the pixel, one clock after its address was driven.
- R6: row_end_n is low for one cycle, in the cycle right after the data-ready of the last pixel of each row.
- R7: frame_end_n is low for one cycle, two cycles after the data-ready of the last pixel of the last row.
- R8: Within a frame, the first pixel of the next row appears cfg_hblank+1 cycles after the last pixel of the previous row. The first pixel of the next frame appears cfg_vblank+2 cycles after the last pixel of a frame.
- R9: While run is low in idle, no data-ready pulse appears. When run goes high in idle, the first data-ready comes three cycles after the cycle in which run was set.
- R10: When run is cleared, the row in progress completes with its end-of-row pulse. After that, no further data-ready or end-of-frame pulse appears.
- R11: A change to any cfg_* input made during a frame has no effect on that frame. It takes effect at the next frame.
- R12: exp_rows equals {cfg_exp_hi, cfg_exp_lo} and exp_sub equals cfg_exp_sub, both as captured at the most recent frame start.
- R13: After reset, pix_drdy is 0, pix_data is 0, both strobes are high, and exp_rows and exp_sub are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Readout enable |
| cfg_first_row | input | ROW_W | Window top row |
| cfg_last_row | input | ROW_W | Window bottom row |
| cfg_first_col | input | COL_W | Window left column |
| cfg_last_col | input | COL_W | Window right column |
| cfg_row_skip | input | 1 | Keep every second row |
| cfg_col_skip | input | 1 | Keep every second column |
| cfg_hblank | input | BLK_W | Idle cycles between rows |
| cfg_vblank | input | BLK_W | Idle cycles between frames |
| cfg_exp_hi | input | 8 | Integration time, upper byte |
| cfg_exp_lo | input | 8 | Integration time, lower byte |
| cfg_exp_sub | input | SUB_W | Fine sub-row integration step |
| sample_row | output | ROW_W | Row address to the sample source |
| sample_col | output | COL_W | Column address to the sample source |
| sample_data | input | PIX_W | Sample value at the driven address |
| pix_data | output | PIX_W | Pixel bus |
| pix_drdy | output | 1 | Pixel valid pulse |
| row_end_n | output | 1 | Active-low end-of-row pulse |
| frame_end_n | output | 1 | Active-low end-of-frame pulse |
| exp_rows | output | 16 | Frame-latched integration row count |
| exp_sub | output | SUB_W | Frame-latched sub-row value |

## Verification
A column counter that goes wrong appears on the pixel bus as a wrong value within one clock. It also moves the end-of-row pulse, so a full-frame comparison catches it in the first row. A wrong row step or a wrong last-row decision changes the number of rows. That shows up as a missing or displaced end-of-frame pulse at most one frame later. A shadow copy that loads at the wrong moment causes a window or blanking change made in mid-frame to alter the current frame; exp_rows also changes before the next frame's first pixel. A blanking counter that is off by one shifts every later pixel of the capture by at least one cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ACTIVE,
    ST_HBLANK,
    ST_VBLANK
  } seq_state_e;

  // Smallest window edge along one axis.
  localparam int MIN_SPAN = 4;

  // First coordinate, limited so that a minimum window still fits the array.
  function automatic int clamp_first(input int first, input int dim);
    return (first > dim - MIN_SPAN) ? dim - MIN_SPAN : first;
  endfunction

  // Last coordinate: at least first+3, at most dim-1.
  function automatic int clamp_last(input int first_c, input int last, input int dim);
    int lo;
    lo = first_c + MIN_SPAN - 1;
    if (last < lo) return lo;
    if (last > dim - 1) return dim - 1;
    return last;
  endfunction

  function automatic int scan_step(input logic skip);
    return skip ? 2 : 1;
  endfunction

  // True when stepping past pos would leave the window.
  function automatic logic scan_is_last(input int pos, input int step, input int last);
    return (pos + step) > last;
  endfunction

endpackage

// File: rtl/seq_shadow.sv
module seq_shadow
  import seq_pkg::*;
#(
  parameter int ROWS  = 480,
  parameter int COLS  = 640,
  parameter int ROW_W = 9,
  parameter int COL_W = 10,
  parameter int BLK_W = 8,
  parameter int SUB_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] cfg_first_row,
  input  logic [ROW_W-1:0] cfg_last_row,
  input  logic [COL_W-1:0] cfg_first_col,
  input  logic [COL_W-1:0] cfg_last_col,
  input  logic             cfg_row_skip,
  input  logic             cfg_col_skip,
  input  logic [BLK_W-1:0] cfg_hblank,
  input  logic [BLK_W-1:0] cfg_vblank,
  input  logic [7:0]       cfg_exp_hi,
  input  logic [7:0]       cfg_exp_lo,
  input  logic [SUB_W-1:0] cfg_exp_sub,
  output logic [ROW_W-1:0] win_first_row,
  output logic [ROW_W-1:0] win_last_row,
  output logic [COL_W-1:0] win_first_col,
  output logic [COL_W-1:0] win_last_col,
  output logic             row_skip,
  output logic             col_skip,
  output logic [BLK_W-1:0] hblank,
  output logic [BLK_W-1:0] vblank,
  output logic [15:0]      exp_rows,
  output logic [SUB_W-1:0] exp_sub
);

  localparam int ROW_RST_LAST = MIN_SPAN - 1;
  localparam int COL_RST_LAST = MIN_SPAN - 1;

  logic [ROW_W-1:0] fr_c, lr_c;
  logic [COL_W-1:0] fc_c, lc_c;

  always_comb begin
    fr_c = ROW_W'(clamp_first(int'(cfg_first_row), ROWS));
    lr_c = ROW_W'(clamp_last(int'(fr_c), int'(cfg_last_row), ROWS));
    fc_c = COL_W'(clamp_first(int'(cfg_first_col), COLS));
    lc_c = COL_W'(clamp_last(int'(fc_c), int'(cfg_last_col), COLS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_first_row <= '0;
      win_last_row  <= ROW_W'(ROW_RST_LAST);
      win_first_col <= '0;
      win_last_col  <= COL_W'(COL_RST_LAST);
      row_skip      <= 1'b0;
      col_skip      <= 1'b0;
      hblank        <= '0;
      vblank        <= '0;
      exp_rows      <= '0;
      exp_sub       <= '0;
    end else if (load) begin
      win_first_row <= fr_c;
      win_last_row  <= lr_c;
      win_first_col <= fc_c;
      win_last_col  <= lc_c;
      row_skip      <= cfg_row_skip;
      col_skip      <= cfg_col_skip;
      hblank        <= cfg_hblank;
      vblank        <= cfg_vblank;
      exp_rows      <= {cfg_exp_hi, cfg_exp_lo};
      exp_sub       <= cfg_exp_sub;
    end
  end

endmodule

// File: rtl/seq_scan_fsm.sv
module seq_scan_fsm
  import seq_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int COL_W = 10,
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ROW_W-1:0] win_first_row,
  input  logic [ROW_W-1:0] win_last_row,
  input  logic [COL_W-1:0] win_first_col,
  input  logic [COL_W-1:0] win_last_col,
  input  logic             row_skip,
  input  logic             col_skip,
  input  logic [BLK_W-1:0] hblank,
  input  logic [BLK_W-1:0] vblank,
  output logic [ROW_W-1:0] sample_row,
  output logic [COL_W-1:0] sample_col,
  output logic             frame_load,
  output logic             ev_pixel,
  output logic             ev_row_done,
  output logic             ev_frame_done,
  output logic             state_idle
);

  seq_state_e       state;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [BLK_W-1:0] cnt;
  int               rstep, cstep;
  logic             col_last, row_last;
  logic             hblank_zero, vblank_zero, cnt_done;

  always_comb begin
    rstep       = scan_step(row_skip);
    cstep       = scan_step(col_skip);
    col_last    = scan_is_last(int'(col), cstep, int'(win_last_col));
    row_last    = scan_is_last(int'(row), rstep, int'(win_last_row));
    hblank_zero = (hblank == '0);
    vblank_zero = (vblank == '0);
    cnt_done    = (cnt == BLK_W'(1));
  end

  assign ev_pixel      = (state == ST_ACTIVE);
  assign ev_row_done   = ev_pixel && col_last;
  assign ev_frame_done = ev_row_done && row_last;
  assign state_idle    = (state == ST_IDLE);
  assign sample_row    = row;
  assign sample_col    = col;

  always_comb begin
    unique case (state)
      ST_IDLE:   frame_load = run;
      ST_ACTIVE: frame_load = ev_frame_done && vblank_zero && run;
      ST_VBLANK: frame_load = cnt_done && run;
      default:   frame_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      row   <= '0;
      col   <= '0;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (run) state <= ST_LOAD;
        end
        ST_LOAD: begin
          row   <= win_first_row;
          col   <= win_first_col;
          state <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (!col_last) begin
            col <= COL_W'(int'(col) + cstep);
          end else begin
            col <= win_first_col;
            if (row_last) begin
              if (!vblank_zero) begin
                cnt   <= vblank;
                state <= ST_VBLANK;
              end else begin
                state <= run ? ST_LOAD : ST_IDLE;
              end
            end else if (!run) begin
              state <= ST_IDLE;
            end else begin
              row <= ROW_W'(int'(row) + rstep);
              if (!hblank_zero) begin
                cnt   <= hblank;
                state <= ST_HBLANK;
              end
            end
          end
        end
        ST_HBLANK: begin
          if (cnt_done) state <= run ? ST_ACTIVE : ST_IDLE;
          else          cnt   <= cnt - BLK_W'(1);
        end
        ST_VBLANK: begin
          if (cnt_done) state <= run ? ST_LOAD : ST_IDLE;
          else          cnt   <= cnt - BLK_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seq_strobe_out.sv
module seq_strobe_out #(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_pixel,
  input  logic             ev_row_done,
  input  logic             ev_frame_done,
  input  logic [PIX_W-1:0] sample_data,
  output logic [PIX_W-1:0] pix_data,
  output logic             pix_drdy,
  output logic             row_end_n,
  output logic             frame_end_n
);

  // Delay line so the row strobe trails its last pixel by one cycle
  // and the frame strobe trails it by two.
  localparam int FRAME_LAG = 2;

  logic                 row_q;
  logic [FRAME_LAG-1:0] frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_data    <= '0;
      pix_drdy    <= 1'b0;
      row_q       <= 1'b0;
      frame_q     <= '0;
      row_end_n   <= 1'b1;
      frame_end_n <= 1'b1;
    end else begin
      if (ev_pixel) pix_data <= sample_data;
      pix_drdy    <= ev_pixel;
      row_q       <= ev_row_done;
      row_end_n   <= ~row_q;
      frame_q     <= {frame_q[FRAME_LAG-2:0], ev_frame_done};
      frame_end_n <= ~frame_q[FRAME_LAG-1];
    end
  end

endmodule

// File: rtl/sensor_readout_seq.sv
module sensor_readout_seq
  import seq_pkg::*;
#(
  parameter int ROWS  = 480,
  parameter int COLS  = 640,
  parameter int PIX_W = 10,
  parameter int BLK_W = 8,
  parameter int SUB_W = 8,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ROW_W-1:0] cfg_first_row,
  input  logic [ROW_W-1:0] cfg_last_row,
  input  logic [COL_W-1:0] cfg_first_col,
  input  logic [COL_W-1:0] cfg_last_col,
  input  logic             cfg_row_skip,
  input  logic             cfg_col_skip,
  input  logic [BLK_W-1:0] cfg_hblank,
  input  logic [BLK_W-1:0] cfg_vblank,
  input  logic [7:0]       cfg_exp_hi,
  input  logic [7:0]       cfg_exp_lo,
  input  logic [SUB_W-1:0] cfg_exp_sub,
  output logic [ROW_W-1:0] sample_row,
  output logic [COL_W-1:0] sample_col,
  input  logic [PIX_W-1:0] sample_data,
  output logic [PIX_W-1:0] pix_data,
  output logic             pix_drdy,
  output logic             row_end_n,
  output logic             frame_end_n,
  output logic [15:0]      exp_rows,
  output logic [SUB_W-1:0] exp_sub
);

  // Named internal events, visible to the bound checker.
  logic             frame_load;
  logic             ev_pixel;
  logic             ev_row_done;
  logic             ev_frame_done;
  logic             state_idle;
  logic [ROW_W-1:0] win_first_row, win_last_row;
  logic [COL_W-1:0] win_first_col, win_last_col;
  logic             row_skip, col_skip;
  logic [BLK_W-1:0] hblank, vblank;

  seq_shadow #(
    .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W),
    .BLK_W(BLK_W), .SUB_W(SUB_W)
  ) u_shadow (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (frame_load),
    .cfg_first_row (cfg_first_row),
    .cfg_last_row  (cfg_last_row),
    .cfg_first_col (cfg_first_col),
    .cfg_last_col  (cfg_last_col),
    .cfg_row_skip  (cfg_row_skip),
    .cfg_col_skip  (cfg_col_skip),
    .cfg_hblank    (cfg_hblank),
    .cfg_vblank    (cfg_vblank),
    .cfg_exp_hi    (cfg_exp_hi),
    .cfg_exp_lo    (cfg_exp_lo),
    .cfg_exp_sub   (cfg_exp_sub),
    .win_first_row (win_first_row),
    .win_last_row  (win_last_row),
    .win_first_col (win_first_col),
    .win_last_col  (win_last_col),
    .row_skip      (row_skip),
    .col_skip      (col_skip),
    .hblank        (hblank),
    .vblank        (vblank),
    .exp_rows      (exp_rows),
    .exp_sub       (exp_sub)
  );

  seq_scan_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BLK_W(BLK_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .win_first_row (win_first_row),
    .win_last_row  (win_last_row),
    .win_first_col (win_first_col),
    .win_last_col  (win_last_col),
    .row_skip      (row_skip),
    .col_skip      (col_skip),
    .hblank        (hblank),
    .vblank        (vblank),
    .sample_row    (sample_row),
    .sample_col    (sample_col),
    .frame_load    (frame_load),
    .ev_pixel      (ev_pixel),
    .ev_row_done   (ev_row_done),
    .ev_frame_done (ev_frame_done),
    .state_idle    (state_idle)
  );

  seq_strobe_out #(
    .PIX_W(PIX_W)
  ) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_pixel      (ev_pixel),
    .ev_row_done   (ev_row_done),
    .ev_frame_done (ev_frame_done),
    .sample_data   (sample_data),
    .pix_data      (pix_data),
    .pix_drdy      (pix_drdy),
    .row_end_n     (row_end_n),
    .frame_end_n   (frame_end_n)
  );

endmodule

// File: rtl/seq_readout_checker.sv
module seq_readout_checker #(
  parameter int ROW_W = 9,
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_load,
  input logic             ev_pixel,
  input logic             ev_row_done,
  input logic             ev_frame_done,
  input logic             state_idle,
  input logic [ROW_W-1:0] win_first_row,
  input logic [ROW_W-1:0] win_last_row,
  input logic [COL_W-1:0] win_first_col,
  input logic [COL_W-1:0] win_last_col,
  input logic [ROW_W-1:0] sample_row,
  input logic [COL_W-1:0] sample_col,
  input logic             pix_drdy,
  input logic             row_end_n,
  input logic             frame_end_n,
  input logic [15:0]      exp_rows
);

  p_addr_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pixel |-> (sample_row >= win_first_row) && (sample_row <= win_last_row) &&
                 (sample_col >= win_first_col) && (sample_col <= win_last_col));

  p_min_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !state_idle |-> (int'(win_last_row) >= int'(win_first_row) + 3) &&
                    (int'(win_last_col) >= int'(win_first_col) + 3));

  p_drdy_follows_pixel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pixel |=> pix_drdy);

  p_row_end_after_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_row_done |-> ##2 !row_end_n);

  p_row_end_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !row_end_n |=> row_end_n);

  p_frame_end_after_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done |-> ##3 !frame_end_n);

  p_quiet_when_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_idle && $past(state_idle) && $past(state_idle, 2) && $past(state_idle, 3))
      |-> (!pix_drdy && row_end_n && frame_end_n));

  p_exposure_frame_latched_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> $stable(exp_rows));

endmodule

bind sensor_readout_seq seq_readout_checker #(
  .ROW_W(ROW_W), .COL_W(COL_W)
) u_seq_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_load    (frame_load),
  .ev_pixel      (ev_pixel),
  .ev_row_done   (ev_row_done),
  .ev_frame_done (ev_frame_done),
  .state_idle    (state_idle),
  .win_first_row (win_first_row),
  .win_last_row  (win_last_row),
  .win_first_col (win_first_col),
  .win_last_col  (win_last_col),
  .sample_row    (sample_row),
  .sample_col    (sample_col),
  .pix_drdy      (pix_drdy),
  .row_end_n     (row_end_n),
  .frame_end_n   (frame_end_n),
  .exp_rows      (exp_rows)
);

// File: tb/tb_sensor_readout_seq.sv
module tb_sensor_readout_seq;

  localparam int ROWS  = 12;
  localparam int COLS  = 16;
  localparam int PIX_W = 10;
  localparam int BLK_W = 8;
  localparam int SUB_W = 8;
  localparam int RW    = $clog2(ROWS);
  localparam int CW    = $clog2(COLS);
  localparam int CAP   = 1024;

  typedef struct {
    int fr, lr, fc, lc;
    bit rs, cs;
    int hb, vb;
    int eh, el, es;
  } cfg_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [RW-1:0] cfg_first_row = '0, cfg_last_row = '0;
  logic [CW-1:0] cfg_first_col = '0, cfg_last_col = '0;
  logic cfg_row_skip = 1'b0, cfg_col_skip = 1'b0;
  logic [BLK_W-1:0] cfg_hblank = '0, cfg_vblank = '0;
  logic [7:0] cfg_exp_hi = '0, cfg_exp_lo = '0;
  logic [SUB_W-1:0] cfg_exp_sub = '0;
  logic [RW-1:0] sample_row;
  logic [CW-1:0] sample_col;
  logic [PIX_W-1:0] sample_data;
  logic [PIX_W-1:0] pix_data;
  logic pix_drdy, row_end_n, frame_end_n;
  logic [15:0] exp_rows;
  logic [SUB_W-1:0] exp_sub;

  always #4 clk = ~clk;

  function automatic int pixval(input int r, input int c);
    return (r * 37 + c * 5 + 3) & ((1 << PIX_W) - 1);
  endfunction

  assign sample_data = PIX_W'(pixval(int'(sample_row), int'(sample_col)));

  sensor_readout_seq #(
    .ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .BLK_W(BLK_W), .SUB_W(SUB_W)
  ) dut (.*);

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic             cap_drdy [CAP];
  logic [PIX_W-1:0] cap_data [CAP];
  logic             cap_rend [CAP];
  logic             cap_fend [CAP];
  logic [15:0]      cap_exp  [CAP];
  logic             exp_drdy [CAP];
  int               exp_data [CAP];
  logic             exp_rend [CAP];
  logic             exp_fend [CAP];
  int               exp_len;
  int               frame_first [4];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic apply_cfg(input cfg_t c);
    cfg_first_row = RW'(c.fr);  cfg_last_row = RW'(c.lr);
    cfg_first_col = CW'(c.fc);  cfg_last_col = CW'(c.lc);
    cfg_row_skip  = c.rs;       cfg_col_skip = c.cs;
    cfg_hblank    = BLK_W'(c.hb); cfg_vblank = BLK_W'(c.vb);
    cfg_exp_hi    = 8'(c.eh);   cfg_exp_lo   = 8'(c.el);
    cfg_exp_sub   = SUB_W'(c.es);
  endtask

  function automatic int lim_first(input int f, input int dim);
    return (f > dim - 4) ? dim - 4 : f;
  endfunction

  function automatic int lim_last(input int f, input int l, input int dim);
    if (l < f + 3) return f + 3;
    if (l > dim - 1) return dim - 1;
    return l;
  endfunction

  // Arithmetic model of the output stream, relative to the first data-ready.
  task automatic build_expected(input cfg_t a, input cfg_t b, input int nframes,
                                input int sw, input int stop);
    int t, tl, fr, lr, fc, lc, rs, cs;
    bit done, lastrow;
    cfg_t c;
    for (int k = 0; k < CAP; k++) begin
      exp_drdy[k] = 1'b0; exp_data[k] = 0; exp_rend[k] = 1'b1; exp_fend[k] = 1'b1;
    end
    t = 0; done = 1'b0; exp_len = 0;
    for (int f = 0; f <= nframes && !done; f++) begin
      c  = (f > 0 && sw >= 0) ? b : a;
      fr = lim_first(c.fr, ROWS); lr = lim_last(fr, c.lr, ROWS);
      fc = lim_first(c.fc, COLS); lc = lim_last(fc, c.lc, COLS);
      rs = c.rs ? 2 : 1;          cs = c.cs ? 2 : 1;
      frame_first[f] = t;
      for (int r = fr; r <= lr && !done; r += rs) begin
        for (int cc = fc; cc <= lc; cc += cs) begin
          if (t < CAP) begin exp_drdy[t] = 1'b1; exp_data[t] = pixval(r, cc); end
          t++;
        end
        tl = t - 1;
        lastrow = (r + rs) > lr;
        if (tl + 2 < CAP) begin
          exp_rend[tl + 1] = 1'b0;
          if (lastrow) exp_fend[tl + 2] = 1'b0;
        end
        if (f == nframes - 1 && lastrow && stop < 0) exp_len = tl + 3;
        if (stop >= 0 && tl > stop) begin
          exp_len = tl + 24;
          done = 1'b1;
        end
        t = lastrow ? tl + 2 + c.vb : tl + 1 + c.hb;
      end
    end
  endtask

  // Starts readout, then records the outputs from the first data-ready on.
  task automatic capture(input int len, input int sw, input int stop,
                         input cfg_t nb, output int latency);
    run = 1'b1;
    latency = 0;
    while (!pix_drdy && latency < 200) begin
      @(negedge clk);
      latency++;
    end
    for (int k = 0; k < len; k++) begin
      cap_drdy[k] = pix_drdy;
      cap_data[k] = pix_data;
      cap_rend[k] = row_end_n;
      cap_fend[k] = frame_end_n;
      cap_exp[k]  = exp_rows;
      if (k == sw)   apply_cfg(nb);
      if (k == stop) run = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic compare(input string req_pix);
    int bp, br, bf, kp, kr, kf;
    bp = 0; br = 0; bf = 0; kp = -1; kr = -1; kf = -1;
    for (int k = 0; k < exp_len; k++) begin
      if (cap_drdy[k] !== exp_drdy[k] ||
          (exp_drdy[k] && int'(cap_data[k]) != exp_data[k])) begin
        bp++; if (kp < 0) kp = k;
      end
      if (cap_rend[k] !== exp_rend[k]) begin br++; if (kr < 0) kr = k; end
      if (cap_fend[k] !== exp_fend[k]) begin bf++; if (kf < 0) kf = k; end
    end
    if (kp < 0) kp = 0;
    if (kr < 0) kr = 0;
    if (kf < 0) kf = 0;
    check(bp == 0, req_pix, $sformatf("pixel stream at idx %0d (data)", kp),
          int'(cap_data[kp]), exp_data[kp]);
    check(br == 0, "R6", $sformatf("row_end_n at idx %0d", kr),
          int'(cap_rend[kr]), int'(exp_rend[kr]));
    check(bf == 0, "R7", $sformatf("frame_end_n at idx %0d", kf),
          int'(cap_fend[kf]), int'(exp_fend[kf]));
  endtask

  task automatic park;
    run = 1'b0;
    repeat (600) @(negedge clk);
  endtask

  task automatic scenario(input string req, input cfg_t a, input cfg_t b,
                          input int sw, input int stop, output int lat);
    build_expected(a, b, 2, sw, stop);
    apply_cfg(a);
    capture(exp_len, sw, stop, b, lat);
    compare(req);
    park();
  endtask

  initial begin
    cfg_t a, b;
    int lat, seen;
    repeat (3) @(negedge clk);
    // R13: reset state
    check(pix_drdy == 1'b0 && row_end_n && frame_end_n, "R13", "strobes in reset",
          int'({pix_drdy, row_end_n, frame_end_n}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    check(pix_data == '0 && exp_rows == '0 && exp_sub == '0, "R13", "data/exposure after reset",
          int'(pix_data) + int'(exp_rows), 0);

    // R9: run low keeps the bus silent
    seen = 0;
    repeat (40) begin @(negedge clk); if (pix_drdy) seen++; end
    check(seen == 0, "R9", "drdy while run low", seen, 0);

    // Full array, with blanking (R1 R5 R8 R9)
    a = '{fr:0, lr:11, fc:0, lc:15, rs:0, cs:0, hb:2, vb:3, eh:1, el:2, es:3};
    scenario("R1/R5/R8", a, a, -1, -1, lat);
    check(lat == 3, "R9", "start latency", lat, 3);

    // Panned window, no blanking (R1 R8)
    a = '{fr:3, lr:8, fc:5, lc:12, rs:0, cs:0, hb:0, vb:0, eh:0, el:0, es:0};
    scenario("R1/R8", a, a, -1, -1, lat);

    // Row decimation only (R3)
    a = '{fr:1, lr:10, fc:2, lc:9, rs:1, cs:0, hb:1, vb:1, eh:0, el:0, es:0};
    scenario("R3", a, a, -1, -1, lat);

    // Column decimation only (R4)
    a = '{fr:0, lr:5, fc:3, lc:12, rs:0, cs:1, hb:3, vb:2, eh:0, el:0, es:0};
    scenario("R4", a, a, -1, -1, lat);

    // Both, at the smallest window in the far corner (R3 R4)
    a = '{fr:8, lr:11, fc:12, lc:15, rs:1, cs:1, hb:0, vb:0, eh:0, el:0, es:0};
    scenario("R3/R4", a, a, -1, -1, lat);

    // Clamping: first beyond array edge, last before first (R2)
    a = '{fr:10, lr:2, fc:14, lc:0, rs:0, cs:0, hb:1, vb:0, eh:0, el:0, es:0};
    scenario("R2", a, a, -1, -1, lat);
    a = '{fr:5, lr:6, fc:1, lc:3, rs:0, cs:0, hb:0, vb:2, eh:0, el:0, es:0};
    scenario("R2", a, a, -1, -1, lat);

    // Mid-frame change lands on the next frame (R11 R12)
    a = '{fr:2, lr:7, fc:4, lc:11, rs:0, cs:0, hb:1, vb:2, eh:8'h12, el:8'h34, es:5};
    b = '{fr:0, lr:9, fc:1, lc:14, rs:1, cs:1, hb:3, vb:1, eh:8'hAB, el:8'hCD, es:9};
    build_expected(a, b, 2, 20, -1);
    apply_cfg(a);
    capture(exp_len, 20, -1, b, lat);
    compare("R11");
    check(cap_exp[0] == 16'h1234, "R12", "exp_rows at first frame", int'(cap_exp[0]), 16'h1234);
    check(cap_exp[25] == 16'h1234, "R11", "exp_rows after mid-frame write",
          int'(cap_exp[25]), 16'h1234);
    check(cap_exp[frame_first[1]] == 16'hABCD, "R12", "exp_rows at second frame",
          int'(cap_exp[frame_first[1]]), 16'hABCD);
    check(exp_sub == SUB_W'(9), "R12", "exp_sub after frame start", int'(exp_sub), 9);
    park();

    // Run cleared mid-row: row finishes, then silence (R10)
    a = '{fr:0, lr:11, fc:0, lc:15, rs:0, cs:0, hb:1, vb:1, eh:0, el:0, es:0};
    scenario("R10", a, a, -1, 42, lat);
    seen = 0;
    for (int k = 0; k < exp_len; k++) if (cap_drdy[k]) seen++;
    check(seen == 48, "R10", "pixels before parking", seen, 48);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule